// File: doc/BRIEF.md
# IR Carrier Modulating Transmitter

This block plays a queue of pulse-width records onto an infrared emitter pin. Each record is written into a small transmit FIFO and carries a logic level and a duration count. A sequencer pulls the records one at a time and holds each level for its duration, measured in carrier ticks. When modulation is on, the output is keyed with a carrier during the level that carries the burst. The carrier's tick length and duty cycle are programmable.

A tick lasts `divider + 1` reference clocks. One carrier period is 16 ticks. The duty field sets how many of those ticks are high. A polarity input picks whether the burst belongs to a mark or to a space. A service request tells the feeding logic when the FIFO needs more records. It can be set to trigger at half empty or only at empty. The block is fed directly by a host-side writer and has no bus interface of its own.

Top module: `irtx_top`

## Requirements
- R1: A record is written as `wr_data[16]` = level and `wr_data[15:0]` = count. It lasts count×4 ticks, each tick being `divider`+1 clock cycles. The first cycle of the record follows the cycle in which it is taken from the FIFO.
- R2: A record whose count is 0 lasts exactly as long as a record with count 1 (4 ticks).
- R3: With `mod_en`=1 and `pol_inv`=0, a level-1 record outputs a carrier and a level-0 record outputs 0. The carrier is high during ticks 0..`duty` of every 16-tick period. The tick count restarts at 0 at the start of each record.
- R4: With `mod_en`=1 and `pol_inv`=1, the roles swap: a level-0 record outputs the carrier of R3 and a level-1 record outputs 0.
- R5: With `mod_en`=0, `ir_out` equals the record level for the whole record, whatever the value of `pol_inv`.
- R6: When another record is waiting as the current one ends, it starts on the very next cycle with no gap, and its carrier phase starts again from tick 0.
- R7: When the FIFO runs dry, `busy` falls and `ir_out` is 0 on the cycle after the last record ends. Both are 0 after reset.
- R8: While enabled, `svc_req` is high when the FIFO holds 4 or fewer entries (`wm_empty`=0), or when it holds 0 entries (`wm_empty`=1).
- R9: The FIFO holds 8 records. A write to a full FIFO is dropped.
- R10: While `tx_en` is 0, the FIFO is emptied, writes are discarded, `busy`, `ir_out` and `svc_req` are 0, and any record in progress stops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 17 | Record: bit 16 level, bits 15:0 duration count |
| divider | input | 16 | Tick length is divider+1 clocks |
| duty | input | 4 | Carrier high for duty+1 of 16 ticks |
| mod_en | input | 1 | Key the burst level with the carrier |
| pol_inv | input | 1 | 0: mark carries burst, 1: space carries burst |
| tx_en | input | 1 | Transmitter enable; low flushes and stops |
| wm_empty | input | 1 | Service request at empty instead of half empty |
| ir_out | output | 1 | Emitter drive |
| busy | output | 1 | A record is being played |
| svc_req | output | 1 | FIFO wants more records |

## Verification
A sweep plays single records over every combination of level, small counts including zero, dividers 0 to 2, duty values at both extremes and the middle, modulation on and off, and both polarities. Each output cycle is compared with a value computed from the tick index. This separates errors in tick length, in carrier phase and duty, and in polarity and level handling. A pair of records played back to back shows whether the join has a gap and whether the phase restarts. A fill sequence behind a long record steps the FIFO through every occupancy under both watermark settings, and the total busy time shows that the ninth write was dropped. A mid-record disable, followed by a write while disabled, shows the flush.

// File: rtl/irtx_pkg.sv
// Package: shared constants for the IR transmitter.
// Assumes the carrier period is a power of two so the phase counter wraps naturally.
package irtx_pkg;
    localparam int TICKS_PER_PERIOD = 16;
    localparam int PHASE_W          = $clog2(TICKS_PER_PERIOD);
    localparam int DUR_SHIFT        = 2;
    localparam int DEF_DEPTH        = 8;
    localparam int DEF_DIV_W        = 16;
    localparam int DEF_CNT_W        = 16;
endpackage

// File: rtl/irtx_fifo.sv
// Module: record FIFO with occupancy count and flush.
// Assumes DEPTH is a power of two. A write to a full FIFO is dropped, even
// if a pop happens in the same cycle. Flush empties the FIFO and blocks writes.
module irtx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 17,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_wr;
    logic          do_rd;

    assign empty   = (count == '0);
    assign do_wr   = wr_en && !flush && (count != CW'(DEPTH));
    assign do_rd   = pop && !flush && !empty;
    assign rd_data = mem[rd_ptr];

    // Store accepted records; storage needs no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Advance pointers and occupancy; flush or reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/irtx_tick_gen.sv
// Module: tick prescaler and carrier phase counter.
// Produces one tick every divider+1 clocks while run is high. The phase
// counts ticks modulo the carrier period, and carrier_hi is high for
// phase 0..duty. restart puts both counters back to zero for a new record.
module irtx_tick_gen
    import irtx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [DIV_W-1:0]   divider,
    input  logic [PHASE_W-1:0] duty,
    output logic               tick,
    output logic               carrier_hi
);
    logic [DIV_W-1:0]   presc;
    logic [PHASE_W-1:0] phase;

    assign tick       = run && (presc == divider);
    assign carrier_hi = (phase <= duty);

    // Count reference clocks within one tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) presc <= '0;
        else if (presc == divider)     presc <= '0;
        else                           presc <= presc + 1'b1;
    end

    // Count ticks within one carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) phase <= '0;
        else if (tick)                 phase <= phase + 1'b1;
    end
endmodule

// File: rtl/irtx_sequencer.sv
// Module: record player.
// Takes a record from the FIFO when idle, or on the last tick of the
// current record, and counts its duration down in ticks. A zero count is
// treated as one. Disable stops the current record on the next cycle.
module irtx_sequencer
    import irtx_pkg::*;
#(
    parameter int CNT_W  = 16,
    localparam int REM_W = CNT_W + DUR_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fifo_empty,
    input  logic [CNT_W:0]   rec,
    input  logic             tick,
    output logic             pop,
    output logic             active,
    output logic             level
);
    logic [REM_W-1:0] remain;
    logic [CNT_W-1:0] eff_cnt;
    logic             last_tick;

    assign last_tick = active && tick && (remain == '0);
    assign pop       = enable && !fifo_empty && (!active || last_tick);
    assign eff_cnt   = (rec[CNT_W-1:0] == '0) ? CNT_W'(1) : rec[CNT_W-1:0];

    // Load, count down and retire records.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            active <= 1'b0;
            level  <= 1'b0;
            remain <= '0;
        end else if (pop) begin
            active <= 1'b1;
            level  <= rec[CNT_W];
            remain <= {eff_cnt, {DUR_SHIFT{1'b0}}} - 1'b1;
        end else if (last_tick) begin
            active <= 1'b0;
        end else if (active && tick) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/irtx_top.sv
// Module: IR carrier modulating transmitter top.
// Wires the FIFO, sequencer and tick generator together. The emitter
// output is formed from the record level, the polarity and the carrier.
// The output is 0 when idle. The config inputs are assumed static while
// a record plays.
module irtx_top
    import irtx_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int DIV_W  = DEF_DIV_W,
    parameter int CNT_W  = DEF_CNT_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CNT_W:0]     wr_data,
    input  logic [DIV_W-1:0]   divider,
    input  logic [PHASE_W-1:0] duty,
    input  logic               mod_en,
    input  logic               pol_inv,
    input  logic               tx_en,
    input  logic               wm_empty,
    output logic               ir_out,
    output logic               busy,
    output logic               svc_req
);
    logic [CNT_W:0]  rec;
    logic            fifo_empty;
    logic [CW-1:0]   fifo_cnt;
    logic            pop;
    logic            active;
    logic            level;
    logic            tick;
    logic            carrier_hi;
    logic            burst;

    irtx_fifo #(.DEPTH(DEPTH), .W(CNT_W + 1)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!tx_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .rd_data (rec),
        .empty   (fifo_empty),
        .count   (fifo_cnt)
    );

    irtx_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_en),
        .fifo_empty (fifo_empty),
        .rec        (rec),
        .tick       (tick),
        .pop        (pop),
        .active     (active),
        .level      (level)
    );

    irtx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (active),
        .restart    (pop),
        .divider    (divider),
        .duty       (duty),
        .tick       (tick),
        .carrier_hi (carrier_hi)
    );

    // Decide whether the current level carries the burst.
    always_comb burst = level ^ pol_inv;

    // Drive the emitter: carrier keyed burst, or the raw level.
    always_comb begin
        if (!active)     ir_out = 1'b0;
        else if (mod_en) ir_out = burst && carrier_hi;
        else             ir_out = level;
    end

    assign busy    = active;
    assign svc_req = tx_en && (wm_empty ? (fifo_cnt == '0)
                                        : (fifo_cnt <= CW'(DEPTH / 2)));
endmodule

// File: rtl/irtx_checker.sv
// Module: property checker for irtx_top, attached by bind.
// Assumes synchronous active-low reset. It observes only ports and the
// FIFO occupancy.
module irtx_checker #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_en,
    input logic          wm_empty,
    input logic          busy,
    input logic          ir_out,
    input logic          svc_req,
    input logic [CW-1:0] fifo_cnt
);
    assert_idle_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ir_out);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!busy && fifo_cnt == '0));

    assert_svc_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !svc_req);

    assert_svc_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && fifo_cnt == '0) |-> svc_req);

    assert_svc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt > CW'(DEPTH / 2)) |-> !svc_req);

    assert_svc_watermark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_empty && fifo_cnt != '0) |-> !svc_req);
endmodule

bind irtx_top irtx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .wm_empty (wm_empty),
    .busy     (busy),
    .ir_out   (ir_out),
    .svc_req  (svc_req),
    .fifo_cnt (fifo_cnt)
);

// File: tb/irtx_top_tb.sv
// Bench for irtx_top: sweeps record settings and compares every cycle
// against values computed from the tick index.
module irtx_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [16:0] wr_data;
    logic [15:0] divider;
    logic [3:0]  duty;
    logic        mod_en;
    logic        pol_inv;
    logic        tx_en;
    logic        wm_empty;
    logic        ir_out;
    logic        busy;
    logic        svc_req;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irtx_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .divider(divider), .duty(duty), .mod_en(mod_en), .pol_inv(pol_inv),
        .tx_en(tx_en), .wm_empty(wm_empty), .ir_out(ir_out), .busy(busy),
        .svc_req(svc_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_out(input bit lvl, input bit md, input bit pl,
                                   input int dt, input int k, input int d);
        int ph;
        ph = (k / (d + 1)) % 16;
        if (!md) return lvl;
        return (lvl ^ pl) && (ph <= dt);
    endfunction

    // Push one record at a negedge; return at the next negedge with wr_en low.
    task automatic push(input bit lvl, input int cnt);
        wr_data = {lvl, 16'(cnt)};
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Compare a whole record cycle by cycle, starting at the current negedge.
    task automatic play(input bit lvl, input int cnt, input string req);
        int len;
        int bad;
        int bk;
        int ba;
        int be;
        len = ((cnt == 0) ? 1 : cnt) * 4 * (int'(divider) + 1);
        bad = 0; bk = 0; ba = 0; be = 0;
        for (int k = 0; k < len; k++) begin
            bit e;
            e = exp_out(lvl, mod_en, pol_inv, int'(duty), k, int'(divider));
            if (bad == 0 && (ir_out !== e || busy !== 1'b1)) begin
                bad = 1; bk = k; ba = {busy, ir_out}; be = {1'b1, e};
            end
            @(negedge clk);
        end
        chk(bad == 0, req, $sformatf("busy,ir_out at offset %0d", bk), ba, be);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int busy_cyc;
        string rq;
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; divider = '0; duty = '0;
        mod_en = 1'b0; pol_inv = 1'b0; tx_en = 1'b1; wm_empty = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk(busy == 1'b0 && ir_out == 1'b0, "R7", "reset busy,ir_out", {busy, ir_out}, 0);
        chk(svc_req == 1'b1, "R8", "svc_req empty after reset", svc_req, 1);

        // R1 R2 R3 R4 R5 sweep of single records
        for (int d = 0; d < 3; d++)
            for (int di = 0; di < 3; di++)
                for (int m = 0; m < 2; m++)
                    for (int p = 0; p < 2; p++)
                        for (int l = 0; l < 2; l++)
                            for (int c = 0; c < 3; c++) begin
                                divider = 16'(d);
                                duty    = (di == 0) ? 4'd0 : (di == 1) ? 4'd7 : 4'd15;
                                mod_en  = m[0];
                                pol_inv = p[0];
                                if (c == 0)      rq = "R2";
                                else if (m == 0) rq = "R1 R5";
                                else if (p == 0) rq = "R1 R3";
                                else             rq = "R4";
                                push(l[0], c);
                                @(negedge clk);
                                play(l[0], c, rq);
                                chk(busy == 1'b0 && ir_out == 1'b0, "R7",
                                    "idle after record", {busy, ir_out}, 0);
                            end

        // R3 long record spans several carrier periods
        divider = 16'd1; duty = 4'd5; mod_en = 1'b1; pol_inv = 1'b0;
        push(1'b1, 12);
        @(negedge clk);
        play(1'b1, 12, "R3");

        // R6 back-to-back records, phase restart
        divider = 16'd1; duty = 4'd3; mod_en = 1'b1; pol_inv = 1'b0;
        push(1'b1, 3);
        push(1'b1, 2);
        play(1'b1, 3, "R6");
        play(1'b1, 2, "R6");
        chk(busy == 1'b0 && ir_out == 1'b0, "R7", "idle after chain", {busy, ir_out}, 0);

        // R8 R9 fill behind a long record
        divider = 16'd0; mod_en = 1'b0; pol_inv = 1'b0;
        push(1'b1, 100);
        @(negedge clk);
        busy_cyc = 0;
        for (int i = 0; i <= 9; i++) begin
            int occ;
            occ = (i > 8) ? 8 : i;
            if (i > 0) begin
                wr_data = {1'b1, 16'd1};
                wr_en   = 1'b1;
                @(negedge clk);
                wr_en   = 1'b0;
                busy_cyc++;
            end
            wm_empty = 1'b0; #1;
            chk(svc_req == (occ <= 4), "R8", $sformatf("half watermark at %0d", occ),
                svc_req, (occ <= 4));
            wm_empty = 1'b1; #1;
            chk(svc_req == (occ == 0), "R8", $sformatf("empty watermark at %0d", occ),
                svc_req, (occ == 0));
            wm_empty = 1'b0;
        end
        // busy_cyc counts negedges since the long record's offset 0, which was busy
        busy_cyc++;
        while (busy && busy_cyc < 2000) begin
            @(negedge clk);
            if (busy) busy_cyc++;
        end
        chk(busy_cyc == 432, "R9", "busy cycles with full FIFO", busy_cyc, 432);

        // R10 disable mid-record flushes queue
        push(1'b1, 50);
        push(1'b1, 1);
        push(1'b1, 1);
        push(1'b1, 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && ir_out == 1'b0, "R10", "stop after disable", {busy, ir_out}, 0);
        chk(svc_req == 1'b0, "R10", "svc_req while disabled", svc_req, 0);
        push(1'b1, 5);
        tx_en = 1'b1;
        busy_cyc = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (busy) busy_cyc++;
        end
        chk(busy_cyc == 0, "R10", "no playback after flush", busy_cyc, 0);
        chk(svc_req == 1'b1, "R10", "FIFO empty after re-enable", svc_req, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule